// File: doc/BRIEF.md
# Programmable Parallel Port with Handshake

This block gives a processor two 8-bit general-purpose parallel ports (A and B) and one 6-bit port (C), all reached through a small register window. A command register sets the direction of ports A and B and picks one of four configurations for port C. Port C can be plain inputs, plain outputs, or handshake lines. In handshake use, each of A and B gets three lines: an interrupt request, a buffer-full flag and a strobe from the peripheral.

The bus side uses a 3-bit register address, an 8-bit write bus, a combinational read bus, single-cycle read and write enables, an active-low chip enable and an I/O select that must be high. Everything is synchronous to one clock. Strobe inputs are sampled on that clock, so the peripheral must hold each strobe level for at least one clock.

Each output port has a latch that is held at zero while its port is an input. A switch from input to output therefore always starts from all-zero pins. Writing the value a latch already holds leaves its pins untouched.

Top module: `pio_hs_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), all output enables are low, all output latches hold zero, the command register holds zero and rdata is zero while no read is active.
- R2: A bus access takes effect only when ce_n is 0 and io_m is 1. Otherwise writes change nothing and rdata reads 0.
- R3: Register address 0 is command on write and status on read. Address 1 is port A, 2 is port B and 3 is port C. Addresses 4 to 7 read as 0, and writes to them change nothing.
- R4: Command bit 0 sets port A output (pa_oe = 1) and bit 1 sets port B output. Bits 4 and 5 are the interrupt-enable flags of A and B. They only appear in the status word.
- R5: Command bits 3:2 set port C. 00 makes every line an input. 11 makes every line an output driven by the port C latch. 01 gives A handshake on lines 2:0 and latch outputs on lines 5:3. 10 gives A handshake on 2:0 and B handshake on 5:3. In a handshake group, the lowest line is the interrupt output, the middle line is the buffer-full output and the top line is the strobe input.
- R6: A port in output mode drives its latch value on its pins one clock after the write, and a read of that port returns the latch. A port C read returns the driven value on output lines and the pin value on input lines.
- R7: While a port is an input, its latch is zero and port writes are dropped. On a change from input to output the pins are zero.
- R8: A port in plain input mode reads back its input pins.
- R9: Any command write that leaves a port in handshake use sets that port's buffer-full to 0 and its interrupt to the port's direction bit (1 for output).
- R10: Handshake input: a falling strobe captures the pins and sets buffer-full. A rising strobe sets the interrupt. A read of the port returns the captured byte and clears both flags. A strobe edge wins over a read in the same cycle.
- R11: Handshake output: a port write sets buffer-full and clears the interrupt. A falling strobe clears buffer-full and a rising strobe sets the interrupt. A strobe edge wins over a write in the same cycle.
- R12: A status read returns bit 0 A interrupt, bit 1 A buffer-full, bit 2 A enable, bit 3 B interrupt, bit 4 B buffer-full, bit 5 B enable, and zeros in bits 7:6.
- R13: A write of the value a latch already holds leaves its pins unchanged in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| io_m | input | 1 | I/O select, must be 1 for an access |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 6 | Port C pin levels |
| pc_out | output | 6 | Port C drive value |
| pc_oe | output | 6 | Port C per-line output enable |

## Verification
The bench targets the latch-clear rule. It turns a port to input, writes it, then turns it back to output. A design that kept the latch, or accepted the write, would show stale data instead of zeros. It runs the strobe sequences in both directions and reads the status word between the edges. A design that cleared the flags on the wrong event, or let a read beat a strobe edge, would show wrong flags there and in the random phase. It also re-enters handshake modes with each direction to check the starting interrupt level, and it issues accesses with the chip enable or I/O select wrong, or to the unused addresses, which a loose decoder would act on.

// File: rtl/pio_hs_pkg.sv
// Shared definitions for the parallel port block: widths, register
// addresses, the port C configuration codes and the command layout.
// Assumes a 6-bit command register whose field positions are software visible.
package pio_hs_pkg;
    localparam int PW = 8;   // width of ports A and B
    localparam int CW = 6;   // width of port C
    localparam int NP = 2;   // ports with handshake support
    localparam int AW = 3;   // register address width

    localparam logic [AW-1:0] RA_CMD = 3'd0;
    localparam logic [AW-1:0] RA_PA  = 3'd1;
    localparam logic [AW-1:0] RA_PB  = 3'd2;
    localparam logic [AW-1:0] RA_PC  = 3'd3;

    typedef enum logic [1:0] {
        CM_IN    = 2'b00,
        CM_HS_A  = 2'b01,
        CM_HS_AB = 2'b10,
        CM_OUT   = 2'b11
    } cmode_e;

    typedef struct packed {
        logic   ie_b;
        logic   ie_a;
        cmode_e cmode;
        logic   dir_b;
        logic   dir_a;
    } cmd_t;
endpackage

// File: rtl/pio_hs_latch.sv
// Output latch of one port. It loads on a write while the port is an
// output and is forced to zero while the port is an input.
// Assumes out_en already reflects a command write in the same cycle.
module pio_hs_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         out_en,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // latch register: clear on input mode, load on write otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (!out_en) q <= '0;
        else if (load)    q <= d;
    end

    p_same_value_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (load && out_en && d == q) |=> $stable(q));
    p_input_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en) |=> (q == '0));
endmodule

// File: rtl/pio_hs_shake.sv
// Handshake flags of one port: buffer-full, interrupt and the input
// capture buffer, driven by strobe edges and CPU accesses to the port.
// Assumes the strobe is synchronous and held for at least one clock.
module pio_hs_shake #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         dir_out,
    input  logic         stb,
    input  logic         cpu_rd,
    input  logic         cpu_wr,
    input  logic [W-1:0] pins,
    output logic         bf,
    output logic         intr,
    output logic [W-1:0] cap
);
    logic stb_q;
    logic fall;
    logic rise;

    assign fall = stb_q & ~stb;
    assign rise = ~stb_q & stb;

    // previous strobe level for edge detection (idle high)
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b1;
        else        stb_q <= stb;
    end

    // flag and capture update; strobe edges win over CPU accesses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bf   <= 1'b0;
            intr <= 1'b0;
            cap  <= '0;
        end else if (init) begin
            bf   <= 1'b0;
            intr <= dir_out;
        end else if (!dir_out) begin
            if (fall) begin
                cap <= pins;
                bf  <= 1'b1;
            end else if (cpu_rd) begin
                bf  <= 1'b0;
            end
            if (rise)        intr <= 1'b1;
            else if (cpu_rd) intr <= 1'b0;
        end else begin
            if (fall)        bf <= 1'b0;
            else if (cpu_wr) bf <= 1'b1;
            if (rise)        intr <= 1'b1;
            else if (cpu_wr) intr <= 1'b0;
        end
    end

    p_init_levels_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (!bf && intr == $past(dir_out)));
    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!init && !dir_out && cpu_rd && !fall && !rise) |=> (!bf && !intr));
endmodule

// File: rtl/pio_hs_port.sv
// Top of the parallel port: bus decode, command register, port C
// configuration, read multiplexer and one latch and handshake unit per port.
// Assumes single-cycle synchronous read and write strobes from the bus.
module pio_hs_port
    import pio_hs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          io_m,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic          pa_oe,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic          pb_oe,
    input  logic [CW-1:0] pc_in,
    output logic [CW-1:0] pc_out,
    output logic [CW-1:0] pc_oe
);
    localparam int GRP = CW / NP;   // port C lines per handshake group

    logic acc, wr, rd, cmd_wr;
    cmd_t cmd_q, cmd_nxt;
    logic [NP-1:0][PW-1:0] pin_in, lat_q, cap_q, port_view;
    logic [NP-1:0] dir_cur, dir_nxt, hs_cur, hs_nxt, bf, intr, p_rd, p_wr;
    logic [CW-1:0] lc_q, pc_view;

    assign acc     = ~ce_n & io_m;
    assign wr      = acc & wr_en;
    assign rd      = acc & rd_en;
    assign cmd_wr  = wr && (addr == RA_CMD);
    assign cmd_nxt = cmd_wr ? cmd_t'(wdata[5:0]) : cmd_q;

    assign pin_in[0] = pa_in;
    assign pin_in[1] = pb_in;
    assign dir_cur   = {cmd_q.dir_b, cmd_q.dir_a};
    assign dir_nxt   = {cmd_nxt.dir_b, cmd_nxt.dir_a};

    // command register
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_nxt;
    end

    for (genvar g = 0; g < NP; g++) begin : g_port
        assign hs_cur[g] = (cmd_q.cmode == CM_HS_AB) ||
                           ((g == 0) && cmd_q.cmode == CM_HS_A);
        assign hs_nxt[g] = (cmd_nxt.cmode == CM_HS_AB) ||
                           ((g == 0) && cmd_nxt.cmode == CM_HS_A);
        assign p_rd[g] = rd && (addr == AW'(g + 1));
        assign p_wr[g] = wr && (addr == AW'(g + 1));
        assign port_view[g] = dir_cur[g] ? lat_q[g] :
                              (hs_cur[g] ? cap_q[g] : pin_in[g]);

        pio_hs_latch #(.W(PW)) u_lat (
            .clk(clk), .rst_n(rst_n), .out_en(dir_nxt[g]),
            .load(p_wr[g]), .d(wdata[PW-1:0]), .q(lat_q[g])
        );

        pio_hs_shake #(.W(PW)) u_shk (
            .clk(clk), .rst_n(rst_n), .init(!hs_nxt[g] || cmd_wr),
            .dir_out(dir_nxt[g]), .stb(pc_in[GRP*g+2]),
            .cpu_rd(p_rd[g]), .cpu_wr(p_wr[g]), .pins(pin_in[g]),
            .bf(bf[g]), .intr(intr[g]), .cap(cap_q[g])
        );

        p_input_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !dir_cur[g] |-> (lat_q[g] == '0));
    end

    pio_hs_latch #(.W(CW)) u_lat_c (
        .clk(clk), .rst_n(rst_n), .out_en(cmd_nxt.cmode != CM_IN),
        .load(wr && addr == RA_PC), .d(wdata[CW-1:0]), .q(lc_q)
    );

    assign pa_out = lat_q[0];
    assign pb_out = lat_q[1];
    assign pa_oe  = dir_cur[0];
    assign pb_oe  = dir_cur[1];

    // port C line assignment per configuration
    always_comb begin
        unique case (cmd_q.cmode)
            CM_IN: begin
                pc_oe  = '0;
                pc_out = '0;
            end
            CM_OUT: begin
                pc_oe  = '1;
                pc_out = lc_q;
            end
            CM_HS_A: begin
                pc_oe  = 6'b111011;
                pc_out = {lc_q[5:3], 1'b0, bf[0], intr[0]};
            end
            default: begin
                pc_oe  = 6'b011011;
                pc_out = {1'b0, bf[1], intr[1], 1'b0, bf[0], intr[0]};
            end
        endcase
    end

    assign pc_view = (pc_oe & pc_out) | (~pc_oe & pc_in);

    // read multiplexer, zero when no valid read
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (addr)
                RA_CMD:  rdata = {2'b00, cmd_q.ie_b, bf[1], intr[1],
                                  cmd_q.ie_a, bf[0], intr[0]};
                RA_PA:   rdata = port_view[0];
                RA_PB:   rdata = port_view[1];
                RA_PC:   rdata = {2'b00, pc_view};
                default: rdata = '0;
            endcase
        end
    end

    p_no_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(cmd_q));
    p_hs_b_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[3:2] == 2'b10) |=> (!pc_out[4] && pc_out[3] == pb_oe));
endmodule

// File: tb/pio_hs_port_bench.sv
module pio_hs_port_bench;
    localparam int PERIOD = 10;
    localparam int RAND_CYCLES = 4000;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, io_m = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, pa_in = '0, pb_in = '0;
    logic [5:0] pc_in = 6'h24;
    logic [7:0] rdata, pa_out, pb_out;
    logic pa_oe, pb_oe;
    logic [5:0] pc_out, pc_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit run = 1'b0;

    pio_hs_port u_pio_hs_port (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .io_m(io_m), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    always #(PERIOD / 2) clk = ~clk;

    // reference model state
    logic [5:0] m_cmd;
    logic [7:0] m_lat [2];
    logic [7:0] m_cap [2];
    logic [5:0] m_lc;
    logic m_bf [2];
    logic m_int [2];
    logic m_sq [2];

    function automatic bit hs_of(int p, logic [5:0] c);
        return (c[3:2] == 2'b10) || (p == 0 && c[3:2] == 2'b01);
    endfunction

    function automatic logic [5:0] exp_pc_oe();
        case (m_cmd[3:2])
            2'b00: return 6'b000000;
            2'b11: return 6'b111111;
            2'b01: return 6'b111011;
            default: return 6'b011011;
        endcase
    endfunction

    function automatic logic [5:0] exp_pc_out();
        case (m_cmd[3:2])
            2'b00: return 6'b000000;
            2'b11: return m_lc;
            2'b01: return {m_lc[5:3], 1'b0, m_bf[0], m_int[0]};
            default: return {1'b0, m_bf[1], m_int[1], 1'b0, m_bf[0], m_int[0]};
        endcase
    endfunction

    function automatic logic [7:0] exp_port(int p);
        if (m_cmd[p]) return m_lat[p];
        if (hs_of(p, m_cmd)) return m_cap[p];
        return (p == 0) ? pa_in : pb_in;
    endfunction

    function automatic logic [7:0] exp_rdata();
        logic [5:0] oe, ov;
        if (!(!ce_n && io_m && rd_en)) return 8'h00;
        oe = exp_pc_oe();
        ov = exp_pc_out();
        case (addr)
            3'd0: return {2'b00, m_cmd[5], m_bf[1], m_int[1], m_cmd[4], m_bf[0], m_int[0]};
            3'd1: return exp_port(0);
            3'd2: return exp_port(1);
            3'd3: return {2'b00, (oe & ov) | (~oe & pc_in)};
            default: return 8'h00;
        endcase
    endfunction

    // model update on each clock from the inputs present at the edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmd = '0; m_lc = '0;
            for (int p = 0; p < 2; p++) begin
                m_lat[p] = '0; m_cap[p] = '0; m_bf[p] = 0; m_int[p] = 0; m_sq[p] = 1;
            end
        end else begin
            bit w, r, cw;
            logic [5:0] nc;
            w  = !ce_n && io_m && wr_en;
            r  = !ce_n && io_m && rd_en;
            cw = w && addr == 3'd0;
            nc = cw ? wdata[5:0] : m_cmd;
            for (int p = 0; p < 2; p++) begin
                bit s, fl, rs, pr, pw;
                s  = pc_in[3 * p + 2];
                fl = m_sq[p] && !s;
                rs = !m_sq[p] && s;
                pr = r && addr == 3'(p + 1);
                pw = w && addr == 3'(p + 1);
                if (!nc[p]) m_lat[p] = '0;
                else if (pw) m_lat[p] = wdata;
                if (!hs_of(p, nc) || cw) begin
                    m_bf[p] = 0; m_int[p] = nc[p];
                end else if (!nc[p]) begin
                    if (fl) begin m_cap[p] = (p == 0) ? pa_in : pb_in; m_bf[p] = 1; end
                    else if (pr) m_bf[p] = 0;
                    if (rs) m_int[p] = 1; else if (pr) m_int[p] = 0;
                end else begin
                    if (fl) m_bf[p] = 0; else if (pw) m_bf[p] = 1;
                    if (rs) m_int[p] = 1; else if (pw) m_int[p] = 0;
                end
                m_sq[p] = s;
            end
            if (nc[3:2] == 2'b00) m_lc = '0;
            else if (w && addr == 3'd3) m_lc = wdata[5:0];
            m_cmd = nc;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // every-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (run) begin
            chk("R4 pa_oe", pa_oe, m_cmd[0]);
            chk("R4 pb_oe", pb_oe, m_cmd[1]);
            chk("R6 pa_out", pa_out, m_lat[0]);
            chk("R6 pb_out", pb_out, m_lat[1]);
            chk("R5 pc_oe", pc_oe, exp_pc_oe());
            chk("R10 pc_out", pc_out, exp_pc_out());
            chk("R12 rdata", rdata, exp_rdata());
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic bus(bit ce, bit io, logic [2:0] a, bit w, bit r, logic [7:0] d);
        @(negedge clk); #1;
        ce_n = ce; io_m = io; addr = a; wr_en = w; rd_en = r; wdata = d;
    endtask

    task automatic idle();
        bus(1, 0, 3'd0, 0, 0, 8'h00);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus(0, 1, a, 1, 0, d);
        idle();
    endtask

    task automatic rd_chk(string tag, logic [2:0] a, logic [7:0] exp);
        bus(0, 1, a, 0, 1, 8'h00);
        #2;
        chk(tag, rdata, exp);
        idle();
    endtask

    task automatic set_pc(logic [5:0] v);
        @(negedge clk); #1;
        pc_in = v;
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        run = 1'b1;
        idle();
        chk("R1 pa_oe", pa_oe, 0);
        chk("R1 pb_oe", pb_oe, 0);
        chk("R1 pc_oe", pc_oe, 0);
        chk("R1 pa_out", pa_out, 0);
        chk("R1 rdata", rdata, 0);

        wr(3'd0, 8'h03);
        chk("R4 both out", {pa_oe, pb_oe}, 2'b11);
        wr(3'd1, 8'h5A);
        chk("R6 latch", pa_out, 8'h5A);
        rd_chk("R6 readback", 3'd1, 8'h5A);
        wr(3'd1, 8'h5A);
        chk("R13 same write", pa_out, 8'h5A);

        bus(1, 1, 3'd1, 1, 0, 8'h11); idle();
        chk("R2 ce_n high", pa_out, 8'h5A);
        bus(0, 0, 3'd1, 1, 0, 8'h22); idle();
        chk("R2 io_m low", pa_out, 8'h5A);
        bus(1, 1, 3'd1, 0, 1, 8'h00); #2;
        chk("R2 read no access", rdata, 0);
        idle();
        wr(3'd4, 8'h77);
        chk("R3 unused write A", pa_out, 8'h5A);
        chk("R3 unused write B", pb_out, 8'h00);
        rd_chk("R3 unused read", 3'd5, 8'h00);

        wr(3'd0, 8'h02);
        chk("R7 cleared", pa_out, 0);
        wr(3'd1, 8'hFF);
        chk("R7 write dropped", pa_out, 0);
        wr(3'd0, 8'h03);
        chk("R7 back to out", {pa_oe, pa_out}, 9'h100);

        pa_in = 8'hC3;
        wr(3'd0, 8'h00);
        rd_chk("R8 pins A", 3'd1, 8'hC3);
        set_pc(6'h2A);
        rd_chk("R8 pins C", 3'd3, 8'h2A);

        wr(3'd0, 8'h0C);
        wr(3'd3, 8'h15);
        chk("R5 mode out oe", pc_oe, 6'h3F);
        chk("R5 mode out val", pc_out, 6'h15);
        rd_chk("R6 C readback", 3'd3, 8'h15);
        set_pc(6'h24);

        wr(3'd0, 8'h14);
        chk("R5 mode A oe", pc_oe, 6'b111011);
        chk("R9 A input init", pc_out[1:0], 2'b00);
        chk("R5 mode A latch", pc_out[5:3], 3'b010);
        wr(3'd0, 8'h0B);
        chk("R5 mode AB oe", pc_oe, 6'b011011);
        chk("R9 out init", {pc_out[4:3], pc_out[1:0]}, 4'b0101);

        wr(3'd0, 8'h18);
        pa_in = 8'h96;
        set_pc(6'h20);
        chk("R10 fall", pc_out[1:0], 2'b10);
        rd_chk("R12 status bf", 3'd0, 8'h06);
        pa_in = 8'h00;
        set_pc(6'h24);
        chk("R10 rise", pc_out[1:0], 2'b11);
        rd_chk("R12 status intr", 3'd0, 8'h07);
        rd_chk("R10 captured", 3'd1, 8'h96);
        chk("R10 read clears", pc_out[1:0], 2'b00);

        wr(3'd0, 8'h0A);
        chk("R9 B out init", pc_out[4:3], 2'b01);
        wr(3'd2, 8'h44);
        chk("R11 write", {pb_out, pc_out[4:3]}, {8'h44, 2'b10});
        set_pc(6'h04);
        chk("R11 fall", pc_out[4:3], 2'b00);
        set_pc(6'h24);
        chk("R11 rise", pc_out[4:3], 2'b01);

        for (int i = 0; i < RAND_CYCLES; i++) begin
            @(negedge clk); #1;
            ce_n  = ($urandom % 8) == 0;
            io_m  = ($urandom % 8) != 0;
            addr  = 3'($urandom);
            wr_en = ($urandom % 3) == 0;
            rd_en = ($urandom % 3) == 0;
            wdata = 8'($urandom);
            pa_in = 8'($urandom);
            pb_in = 8'($urandom);
            if (($urandom % 4) == 0) pc_in[2] = ~pc_in[2];
            if (($urandom % 4) == 0) pc_in[5] = ~pc_in[5];
            pc_in[4:3] = 2'($urandom);
            pc_in[1:0] = 2'($urandom);
        end
        idle();
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule